// File: doc/BRIEF.md
# Wordlength-Reducing Signed Booth Multiplier

This block multiplies two signed 16-bit words. Before the multiply, it can shorten the useful wordlength of each operand, so that fewer bits toggle in the array. Each operand has its own reduction selector. An operand can pass unchanged. It can have its lowest N bits cleared while the remaining bits stay where they are. It can also be shifted N places toward the LSB, with the sign bit copied into the vacated upper positions. One shared amount N applies to both operands.

The reduced words feed a radix-4 modified Booth array. That array recodes only one of its two inputs. A swap control decides whether operand A or operand B takes the recoded role. This lets a system put the operand with less activity on the side where switching costs more. Swapping never changes the numeric result.

The operands and controls are registered on a valid strobe, and the product is registered again. This gives a fixed two-cycle latency.

Top module: `wlr_booth_top`

## Requirements
- R1: With both modes at full length (mode code 2'b00), `product` equals the exact signed 32-bit product of `opa` and `opb`.
- R2: Mode code 2'b01 (truncate) clears the `amt` least significant bits of that operand and keeps every other bit in its original position before the multiply.
- R3: Mode code 2'b10 (shift) arithmetically shifts that operand right by `amt` places, filling the vacated high bits with its sign bit, before the multiply.
- R4: An `amt` of 0 makes truncate and shift modes give the same product as full length.
- R5: Mode code 2'b11 is treated exactly like full length.
- R6: Each operand follows its own mode input. A reduction selected for one operand never alters the other.
- R7: `swap` = 1 makes operand B the Booth-recoded operand instead of A. The product is identical for either value of `swap`.
- R8: A transfer accepted with `in_valid` high at rising edge k appears on `product` with `out_valid` high after rising edge k+1. `out_valid` is low in every other cycle.
- R9: While `rst_n` is low, `out_valid` and `product` are 0.
- R10: `product` holds its last value in cycles where no result is delivered.
- R11: Extreme operands are exact, including -32768 x -32768 = 1073741824, -1 x -1 = 1 and any value times 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opa | input | 16 | Signed operand A |
| opb | input | 16 | Signed operand B |
| mode_a | input | 2 | Reduction mode for A: 00 full, 01 truncate, 10 shift, 11 full |
| mode_b | input | 2 | Reduction mode for B, same encoding |
| amt | input | 4 | Reduction amount N, 0 to 15 |
| swap | input | 1 | 0: A is recoded; 1: B is recoded |
| out_valid | output | 1 | Product valid |
| product | output | 32 | Signed product of the reduced operands |

## Verification
Several properties are checked on every cycle. The valid pipeline timing and the hold of the product register between results are among them. Each delivered product is compared with a plain signed multiply of the two reduced words. On every cycle, the checks also confirm that truncated words have clear low bits, that shifted words keep their sign, and that the recoded input follows the swap setting. Some behaviours can only be shown by the bench's scenarios: the correctness of the reduction arithmetic itself against independently computed values, the equality of swapped and unswapped products for the same inputs, the reset values, and the exact extreme-operand results.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
  typedef enum logic [1:0] {
    RED_FULL  = 2'b00,
    RED_TRUNC = 2'b01,
    RED_SHIFT = 2'b10,
    RED_SPARE = 2'b11
  } red_mode_t;
endpackage

// File: rtl/wlr_reduce.sv
module wlr_reduce #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic [W-1:0]      din,
  input  logic [1:0]        mode,
  input  logic [AW-1:0]     amt,
  output logic [W-1:0]      dout
);
  import wlr_pkg::*;

  // Mask keeps the upper bits and clears the low amt bits.
  function automatic logic [W-1:0] low_clear(logic [W-1:0] v, logic [AW-1:0] n);
    logic [W-1:0] keep_mask;
    keep_mask = {W{1'b1}} << n;
    return v & keep_mask;
  endfunction

  function automatic logic [W-1:0] sign_shift(logic [W-1:0] v, logic [AW-1:0] n);
    return W'($signed(v) >>> n);
  endfunction

  always_comb begin
    case (red_mode_t'(mode))
      RED_TRUNC: dout = low_clear(din, amt);
      RED_SHIFT: dout = sign_shift(din, amt);
      default:   dout = din;
    endcase
  end
endmodule

// File: rtl/wlr_booth_core.sv
module wlr_booth_core #(
  parameter int W = 16
) (
  input  logic [W-1:0]   plain,
  input  logic [W-1:0]   rec,
  output logic [2*W-1:0] prod
);
  localparam int DIGITS = W / 2;
  localparam int PW     = 2 * W;

  // One radix-4 partial product for a recoding triplet.
  function automatic logic [PW-1:0] booth_pp(logic [2:0] trip, logic [W-1:0] x);
    logic [PW-1:0] xe;
    xe = {{W{x[W-1]}}, x};
    case (trip)
      3'b001, 3'b010: return xe;
      3'b011:         return xe << 1;
      3'b100:         return -(xe << 1);
      3'b101, 3'b110: return -xe;
      default:        return '0;
    endcase
  endfunction

  logic [W:0]    rec_ext;
  logic [PW-1:0] pp [DIGITS];

  assign rec_ext = {rec, 1'b0};

  for (genvar g = 0; g < DIGITS; g++) begin : g_pp
    logic [2:0] trip;
    assign trip  = rec_ext[2*g+2 -: 3];
    assign pp[g] = booth_pp(trip, plain) << (2*g);
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < DIGITS; i++) prod = prod + pp[i];
  end
endmodule

// File: rtl/wlr_booth_top.sv
module wlr_booth_top #(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [1:0]      mode_a,
  input  logic [1:0]      mode_b,
  input  logic [AW-1:0]   amt,
  input  logic            swap,
  output logic            out_valid,
  output logic [2*W-1:0]  product
);
  import wlr_pkg::*;
  localparam int PW = 2 * W;

  logic [W-1:0]  a_q, b_q;
  logic [1:0]    ma_q, mb_q;
  logic [AW-1:0] amt_q;
  logic          swap_q, v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; ma_q <= '0; mb_q <= '0;
      amt_q <= '0; swap_q <= 1'b0; v_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= opa; b_q <= opb; ma_q <= mode_a; mb_q <= mode_b;
        amt_q <= amt; swap_q <= swap;
      end
    end
  end

  // Named internal events for the checks below.
  logic [W-1:0]  red_a, red_b, booth_rec, booth_plain;
  logic [PW-1:0] core_prod, mul_cmp;

  wlr_reduce #(.W(W), .AW(AW)) u_red_a (.din(a_q), .mode(ma_q), .amt(amt_q), .dout(red_a));
  wlr_reduce #(.W(W), .AW(AW)) u_red_b (.din(b_q), .mode(mb_q), .amt(amt_q), .dout(red_b));

  assign booth_rec   = swap_q ? red_b : red_a;
  assign booth_plain = swap_q ? red_a : red_b;

  wlr_booth_core #(.W(W)) u_core (.plain(booth_plain), .rec(booth_rec), .prod(core_prod));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= v_q;
      if (v_q) product <= core_prod;
    end
  end

  assign mul_cmp = PW'($signed(red_a) * $signed(red_b));

  // R8
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) v_q |=> out_valid);
  // R8
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !v_q |=> !out_valid);
  // R1
  prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |=> product == $past(mul_cmp));
  // R10
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |=> $stable(product));
  // R2
  trunc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ma_q == RED_TRUNC) |-> ((red_a >> amt_q) << amt_q) == red_a);
  // R3
  shift_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_q == RED_SHIFT) |-> red_b[W-1] == b_q[W-1]);
  // R7
  recode_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_q |-> (booth_rec == red_b && booth_plain == red_a));
endmodule

// File: tb/wlr_booth_top_bench.sv
`timescale 1ns/1ps
module wlr_booth_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic [1:0] mode_a = '0, mode_b = '0;
  logic [3:0] amt = '0;
  logic swap = 1'b0;
  logic out_valid;
  logic [31:0] product;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wlr_booth_top u_wlr_booth_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .mode_a(mode_a), .mode_b(mode_b), .amt(amt), .swap(swap),
    .out_valid(out_valid), .product(product)
  );

  function automatic logic [15:0] ref_reduce(logic [15:0] v, logic [1:0] m, int n);
    logic [15:0] r;
    r = v;
    if (m == 2'b01) begin
      for (int i = 0; i < n; i++) r[i] = 1'b0;
    end else if (m == 2'b10) begin
      for (int i = 0; i < n; i++) r = {r[15], r[15:1]};
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_prod(logic [15:0] a, logic [15:0] b,
                                           logic [1:0] ma, logic [1:0] mb, int n);
    longint ra, rb;
    ra = longint'($signed(ref_reduce(a, ma, n)));
    rb = longint'($signed(ref_reduce(b, mb, n)));
    return 32'(ra * rb);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one transfer, verify timing and value, return the product seen.
  task automatic run(string req, logic [15:0] a, logic [15:0] b, logic [1:0] ma,
                     logic [1:0] mb, logic [3:0] n, logic sw, output logic [31:0] got);
    logic [31:0] exp, prev;
    exp = ref_prod(a, b, ma, mb, int'(n));
    @(negedge clk);
    opa = a; opb = b; mode_a = ma; mode_b = mb; amt = n; swap = sw; in_valid = 1'b1;
    prev = product;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 early", {31'd0, out_valid}, 32'd0);
    check("R10 hold before", product, prev);
    @(negedge clk);
    check("R8 valid", {31'd0, out_valid}, 32'd1);
    check(req, product, exp);
    got = product;
    @(negedge clk);
    check("R8 drop", {31'd0, out_valid}, 32'd0);
    check("R10 hold after", product, got);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] g0, g1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9
    check("R9 valid", {31'd0, out_valid}, 32'd0);
    check("R9 product", product, 32'd0);
    rst_n = 1'b1;

    // R1 and R11 directed corners
    run("R11 minneg", 16'h8000, 16'h8000, 2'b00, 2'b00, 4'd0, 1'b0, g0);
    check("R11 minneg value", g0, 32'h4000_0000);
    run("R11 m1m1", 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 4'd0, 1'b1, g0);
    check("R11 m1m1 value", g0, 32'd1);
    run("R11 zero", 16'h8000, 16'h0000, 2'b00, 2'b00, 4'd3, 1'b0, g0);
    run("R1 maxpos", 16'h7FFF, 16'h8000, 2'b00, 2'b00, 4'd0, 1'b1, g0);
    // R2 truncation to 8 bits
    run("R2 trunc8", 16'h1234, 16'hF0F3, 2'b01, 2'b01, 4'd8, 1'b0, g0);
    check("R2 trunc8 value", g0, 32'(longint'(16'sh1200) * longint'(16'shF000)));
    // R3 shift by 8 with sign fill
    run("R3 shift8", 16'h8100, 16'h0300, 2'b10, 2'b10, 4'd8, 1'b0, g0);
    check("R3 shift8 value", g0, 32'(-127 * 3));
    run("R3 shift15", 16'hFFFF, 16'h8000, 2'b10, 2'b10, 4'd15, 1'b1, g0);
    check("R3 shift15 value", g0, 32'd1);
    // R4 amount zero
    run("R4 trunc0", 16'hABCD, 16'h1357, 2'b01, 2'b10, 4'd0, 1'b0, g0);
    check("R4 equals full", g0, ref_prod(16'hABCD, 16'h1357, 2'b00, 2'b00, 0));
    // R5 spare code
    run("R5 spare", 16'hC001, 16'h7003, 2'b11, 2'b11, 4'd6, 1'b0, g0);
    check("R5 equals full", g0, ref_prod(16'hC001, 16'h7003, 2'b00, 2'b00, 0));
    // R6 independent modes
    run("R6 mixed", 16'h4567, 16'h0089, 2'b01, 2'b00, 4'd4, 1'b0, g0);
    check("R6 B untouched", g0, 32'(longint'(16'sh4560) * longint'(16'sh0089)));
    // R7 swap invariance, directed and random
    run("R7 sw0", 16'h9ABC, 16'h7531, 2'b10, 2'b01, 4'd5, 1'b0, g0);
    run("R7 sw1", 16'h9ABC, 16'h7531, 2'b10, 2'b01, 4'd5, 1'b1, g1);
    check("R7 swap equal", g1, g0);
    for (int i = 0; i < 200; i++) begin
      logic [15:0] a, b;
      logic [1:0] ma, mb;
      logic [3:0] n;
      a = 16'($urandom); b = 16'($urandom);
      if (i % 17 == 0) a = 16'h8000;
      if (i % 13 == 0) b = 16'hFFFF;
      ma = 2'($urandom); mb = 2'($urandom); n = 4'($urandom);
      run("R1 random", a, b, ma, mb, n, 1'b0, g0);
      run("R7 random swapped", a, b, ma, mb, n, 1'b1, g1);
      check("R7 random equal", g1, g0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule